// File: doc/BRIEF.md
# PLL Bypass Sequencer

This block controls the source of the system clock. The source is either the always-running bypass clock or the output of a PLL. It decides when the PLL path may be selected and when the PLL may be powered down. Software reaches it through a small write port. Three addresses hold the multiplier field and the two divider fields. A fourth address holds two level bits: one requests PLL operation and one requests power-down. The block runs on the bypass clock.

Any change to a ratio field takes effect only while the system clock runs from the bypass source. If a ratio write arrives while the PLL is selected, the block first switches back to bypass, applies the field one cycle later, and then starts the settle interval again. A settle timer counts `SETTLE_CYC` bypass-clock cycles. The PLL is selected only after the timer expires and while a request is present. A request made earlier waits as pending. Power-down is applied only after the clock select has reached bypass. Leaving power-down starts a new settle interval. A combinational flag reports when the programmed ratios would put the PLL input or output frequency outside the allowed limits.

Top module: `pll_bypass_seq`

## Requirements
- R1: After reset, `sysclk_sel`=0 (bypass), `pll_pwrdn`=0, `mult_fld`=496, `refdiv_fld`=96, `refdiv_bypass`=0, `outdiv_fld`=0, `outdiv_en`=0, `cfg_bad`=0, `settling`=1 and `req_pending`=0.
- R2: Write address map: address 0 loads `mult_fld` from data[11:0]. Address 1 loads `refdiv_fld` from data[11:0] and `refdiv_bypass` from data[12]. Address 2 loads `outdiv_fld` from data[6:0] and `outdiv_en` from data[7]. When `sysclk_sel`=0, such a write shows on the outputs after the capturing edge and restarts the settle timer, so `settling`=1.
- R3: `sysclk_sel` rises no earlier than the (SETTLE_CYC+1)-th edge after the last timer restart. If the timer has already expired when the request bit is written, `sysclk_sel` rises on that same capturing edge.
- R4: A ratio write while `sysclk_sel`=1 drops `sysclk_sel` on the capturing edge. The field keeps its old value after that edge and takes the new value one edge later. The timer restarts on that later edge, so with the request still set `sysclk_sel` returns SETTLE_CYC+2 edges after the write.
- R5: Address 3, data[0] is a level PLL request. While it is set and the PLL is not selected, `req_pending`=1. The request is granted when the timer expires, and `req_pending` then returns to 0.
- R6: Address 3, data[1] is a level power-down request. From PLL operation, `sysclk_sel` falls on the capturing edge and `pll_pwrdn` rises one edge later. From bypass, `pll_pwrdn` rises on the capturing edge. While `pll_pwrdn`=1, `sysclk_sel` stays 0 even with a request present.
- R7: Clearing data[1] clears `pll_pwrdn` on the capturing edge and restarts the settle timer. A held request is then granted SETTLE_CYC+1 edges later.
- R8: `cfg_bad`=1 exactly when any of the following holds. Take PLLIN = REF_HZ/(refdiv_fld+4), or REF_HZ when `refdiv_bypass`=1, and PLLOUT = PLLIN×(mult_fld+4). The flag is set when PLLIN < 32768 Hz, when PLLIN > 170000 Hz, when PLLOUT < 60 MHz, or when PLLOUT > FMAX_HZ.
- R9: Clearing the request while in PLL operation drops `sysclk_sel` on the capturing edge. It then stays 0 until a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bypass clock, always running |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Field address (0 mult, 1 ref divider, 2 out divider, 3 control) |
| wr_data | input | 16 | Write data |
| sysclk_sel | output | 1 | System clock source: 1 = PLL path, 0 = bypass |
| pll_pwrdn | output | 1 | PLL power-down control |
| mult_fld | output | 12 | Applied multiplier field (ratio = field+4) |
| refdiv_fld | output | 12 | Applied reference divider field (ratio = field+4) |
| refdiv_bypass | output | 1 | Reference divider bypassed |
| outdiv_fld | output | 7 | Applied output divider field (ratio = field+1) |
| outdiv_en | output | 1 | Output divider in use |
| on_pll | output | 1 | Status: system clock currently from the PLL |
| settling | output | 1 | Status: settle timer still running |
| req_pending | output | 1 | Status: PLL requested but not selected |
| cfg_bad | output | 1 | Applied ratios violate the frequency limits |

## Verification
The assertions assume the write port carries one access per cycle and that writes are synchronous to the bypass clock. The stimulus drives every write for exactly one cycle, away from the clock edge, and waits long enough between commands for the settle timer to reach a known state. The settle-hold property also assumes `SETTLE_CYC` is at least 1. The bench uses a short value of 16 so that every expiry, including the one after leaving power-down, is reached many times within the run.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

    localparam int MUL_W  = 12;
    localparam int RDIV_W = 12;
    localparam int ODIV_W = 7;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        A_MUL  = 2'd0,
        A_RDIV = 2'd1,
        A_ODIV = 2'd2,
        A_CTRL = 2'd3
    } addr_e;

    typedef enum logic [1:0] {
        ST_BYP   = 2'd0,
        ST_PLL   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_PD    = 2'd3
    } state_e;

    typedef struct packed {
        logic [MUL_W-1:0]  mul;
        logic [RDIV_W-1:0] rdiv;
        logic              rbyp;
        logic [ODIV_W-1:0] odiv;
        logic              oen;
    } ratio_t;

    localparam ratio_t RATIO_RST = '{mul: 12'd496, rdiv: 12'd96, rbyp: 1'b0,
                                     odiv: 7'd0, oen: 1'b0};

    localparam logic [63:0] PLLIN_MIN_HZ  = 64'd32768;
    localparam logic [63:0] PLLIN_MAX_HZ  = 64'd170000;
    localparam logic [63:0] PLLOUT_MIN_HZ = 64'd60000000;

    // Range test done with products only, so no divider is built.
    function automatic logic cfg_violation(ratio_t r, logic [63:0] ref_hz,
                                           logic [63:0] fmax_hz);
        logic [63:0] div;
        logic [63:0] mul;
        logic [63:0] prod;
        div  = r.rbyp ? 64'd1 : (64'(r.rdiv) + 64'd4);
        mul  = 64'(r.mul) + 64'd4;
        prod = ref_hz * mul;
        return (ref_hz < PLLIN_MIN_HZ * div) || (ref_hz > PLLIN_MAX_HZ * div) ||
               (prod < PLLOUT_MIN_HZ * div) || (prod > fmax_hz * div);
    endfunction

    function automatic ratio_t apply_write(ratio_t r, addr_e a, logic [DATA_W-1:0] d);
        ratio_t n;
        n = r;
        case (a)
            A_MUL:  n.mul = d[MUL_W-1:0];
            A_RDIV: begin
                n.rdiv = d[RDIV_W-1:0];
                n.rbyp = d[RDIV_W];
            end
            A_ODIV: begin
                n.odiv = d[ODIV_W-1:0];
                n.oen  = d[ODIV_W];
            end
            default: n = r;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pllseq_timer.sv
module pllseq_timer #(
    parameter int CYC = 48000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic done
);
    localparam int CNT_W = $clog2(CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYC);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= LOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R3: once expired, the timer stays expired until the next restart
    p_done_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (done && !restart) |=> done);

endmodule

// File: rtl/pllseq_regs.sv
module pllseq_regs
    import pllseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              in_bypass,
    output ratio_t            cur,
    output logic              applied
);
    logic              ratio_wr;
    logic              stg_vld;
    addr_e             stg_addr;
    logic [DATA_W-1:0] stg_data;
    ratio_t            nxt;

    assign ratio_wr = wr_en && (addr_e'(wr_addr) != A_CTRL);

    always_comb begin
        nxt = cur;
        if (stg_vld)
            nxt = apply_write(nxt, stg_addr, stg_data);
        if (ratio_wr && in_bypass)
            nxt = apply_write(nxt, addr_e'(wr_addr), wr_data);
    end

    assign applied = stg_vld || (ratio_wr && in_bypass);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= RATIO_RST;
            stg_vld  <= 1'b0;
            stg_addr <= A_MUL;
            stg_data <= '0;
        end else begin
            cur     <= nxt;
            stg_vld <= ratio_wr && !in_bypass;
            if (ratio_wr && !in_bypass) begin
                stg_addr <= addr_e'(wr_addr);
                stg_data <= wr_data;
            end
        end
    end

    // R4: applied ratios move only after a cycle spent in bypass
    p_ratio_in_bypass_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur) |-> $past(in_bypass));
    // R4: a staged write is only released once the clock select is bypass
    p_stage_after_bypass_r4: assert property (@(posedge clk) disable iff (rst)
        stg_vld |-> in_bypass);

endmodule

// File: rtl/pllseq_fsm.sv
module pllseq_fsm
    import pllseq_pkg::*;
#(
    parameter int SETTLE_CYC = 48000
) (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic ratio_wr,
    input  logic ctrl_req,
    input  logic ctrl_pd,
    input  logic timer_done,
    input  logic applied,
    output logic sel_q,
    output logic pwrdn_q,
    output logic req_q,
    output logic restart
);
    localparam int BC_W = $clog2(SETTLE_CYC + 2);
    localparam logic [BC_W-1:0] BC_MAX = BC_W'(SETTLE_CYC);

    state_e state, state_nx;
    logic   pd_q, req_nx, pd_nx, sel_nx, pwr_nx;
    logic [BC_W-1:0] byp_cnt;

    assign req_nx = ctrl_wr ? ctrl_req : req_q;
    assign pd_nx  = ctrl_wr ? ctrl_pd  : pd_q;

    always_comb begin
        state_nx = state;
        sel_nx   = sel_q;
        pwr_nx   = pwrdn_q;
        restart  = applied;
        case (state)
            ST_BYP: begin
                if (pd_nx) begin
                    state_nx = ST_PD;
                    pwr_nx   = 1'b1;
                end else if (ratio_wr) begin
                    restart = 1'b1;
                end else if (timer_done && !applied && req_nx) begin
                    state_nx = ST_PLL;
                    sel_nx   = 1'b1;
                end
            end
            ST_PLL: begin
                if (pd_nx) begin
                    state_nx = ST_DRAIN;
                    sel_nx   = 1'b0;
                end else if (ratio_wr || !req_nx) begin
                    state_nx = ST_BYP;
                    sel_nx   = 1'b0;
                    restart  = 1'b1;
                end
            end
            ST_DRAIN: begin
                state_nx = ST_PD;
                pwr_nx   = 1'b1;
            end
            default: begin
                if (!pd_nx) begin
                    state_nx = ST_BYP;
                    pwr_nx   = 1'b0;
                    restart  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_BYP;
            sel_q   <= 1'b0;
            pwrdn_q <= 1'b0;
            req_q   <= 1'b0;
            pd_q    <= 1'b0;
            byp_cnt <= '0;
        end else begin
            state   <= state_nx;
            sel_q   <= sel_nx;
            pwrdn_q <= pwr_nx;
            req_q   <= req_nx;
            pd_q    <= pd_nx;
            if (sel_q || pwrdn_q)
                byp_cnt <= '0;
            else if (byp_cnt != BC_MAX)
                byp_cnt <= byp_cnt + 1'b1;
        end
    end

    // R3: the PLL path is chosen only after a full settle interval in bypass
    p_settle_before_pll_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_q) |-> (byp_cnt >= BC_MAX));
    // R5: the PLL path is held only while a request stands
    p_pll_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
        sel_q |-> req_q);
    // R6: power-down follows a cycle in which bypass was already selected
    p_pd_after_bypass_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pwrdn_q) |-> !$past(sel_q));
    // R6: never on the PLL path while powered down
    p_pd_keeps_bypass_r6: assert property (@(posedge clk) disable iff (rst)
        pwrdn_q |-> !sel_q);
    // R7: leaving power-down starts a fresh settle interval
    p_pd_exit_settles_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(pwrdn_q) |-> !timer_done);

endmodule

// File: rtl/pll_bypass_seq.sv
module pll_bypass_seq
    import pllseq_pkg::*;
#(
    parameter int          SETTLE_CYC = 48000,
    parameter logic [63:0] REF_HZ     = 64'd12000000,
    parameter logic [63:0] FMAX_HZ    = 64'd100000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sysclk_sel,
    output logic              pll_pwrdn,
    output logic [MUL_W-1:0]  mult_fld,
    output logic [RDIV_W-1:0] refdiv_fld,
    output logic              refdiv_bypass,
    output logic [ODIV_W-1:0] outdiv_fld,
    output logic              outdiv_en,
    output logic              on_pll,
    output logic              settling,
    output logic              req_pending,
    output logic              cfg_bad
);
    ratio_t cur;
    logic   applied, restart, timer_done, sel_q, pwrdn_q, req_q;
    logic   ctrl_wr, ratio_wr;

    assign ctrl_wr  = wr_en && (addr_e'(wr_addr) == A_CTRL);
    assign ratio_wr = wr_en && (addr_e'(wr_addr) != A_CTRL);

    pllseq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .in_bypass (!sel_q),
        .cur       (cur),
        .applied   (applied)
    );

    pllseq_timer #(.CYC(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .done    (timer_done)
    );

    pllseq_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (ctrl_wr),
        .ratio_wr   (ratio_wr),
        .ctrl_req   (wr_data[0]),
        .ctrl_pd    (wr_data[1]),
        .timer_done (timer_done),
        .applied    (applied),
        .sel_q      (sel_q),
        .pwrdn_q    (pwrdn_q),
        .req_q      (req_q),
        .restart    (restart)
    );

    assign sysclk_sel    = sel_q;
    assign on_pll        = sel_q;
    assign pll_pwrdn     = pwrdn_q;
    assign mult_fld      = cur.mul;
    assign refdiv_fld    = cur.rdiv;
    assign refdiv_bypass = cur.rbyp;
    assign outdiv_fld    = cur.odiv;
    assign outdiv_en     = cur.oen;
    assign settling      = !timer_done;
    assign req_pending   = req_q && !sel_q;
    assign cfg_bad       = cfg_violation(cur, REF_HZ, FMAX_HZ);

endmodule

// File: tb/sim_pll_bypass_seq.sv
module sim_pll_bypass_seq;
    localparam int N = 16;
    localparam int O_SEL = 0, O_PWR = 1, O_MUL = 2, O_RDIV = 3, O_RBYP = 4,
                   O_ODIV = 5, O_OEN = 6, O_BAD = 7, O_SETL = 8, O_PEND = 9, O_ONPLL = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        sysclk_sel, pll_pwrdn, refdiv_bypass, outdiv_en;
    logic        on_pll, settling, req_pending, cfg_bad;
    logic [11:0] mult_fld, refdiv_fld;
    logic [6:0]  outdiv_fld;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int k, k1, k2;
    int got;
    bit finished = 0;

    typedef struct {
        int    at;
        int    id;
        int    val;
        string tag;
    } exp_t;
    exp_t sbq[$];

    pll_bypass_seq #(.SETTLE_CYC(N)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sysclk_sel(sysclk_sel), .pll_pwrdn(pll_pwrdn), .mult_fld(mult_fld),
        .refdiv_fld(refdiv_fld), .refdiv_bypass(refdiv_bypass), .outdiv_fld(outdiv_fld),
        .outdiv_en(outdiv_en), .on_pll(on_pll), .settling(settling),
        .req_pending(req_pending), .cfg_bad(cfg_bad)
    );

    always #10ns clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    function automatic int obs(int id);
        case (id)
            O_SEL:   return int'(sysclk_sel);
            O_PWR:   return int'(pll_pwrdn);
            O_MUL:   return int'(mult_fld);
            O_RDIV:  return int'(refdiv_fld);
            O_RBYP:  return int'(refdiv_bypass);
            O_ODIV:  return int'(outdiv_fld);
            O_OEN:   return int'(outdiv_en);
            O_BAD:   return int'(cfg_bad);
            O_SETL:  return int'(settling);
            O_PEND:  return int'(req_pending);
            default: return int'(on_pll);
        endcase
    endfunction

    task automatic expect_at(int at, int id, int val, string tag);
        exp_t e;
        e.at = at; e.id = id; e.val = val; e.tag = tag;
        sbq.push_back(e);
    endtask

    // Monitor: pop every expectation due after the most recent edge.
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].at == cyc) begin
                checks++;
                got = obs(sbq[i].id);
                if (got != sbq[i].val) begin
                    errors++;
                    $display("FAIL %s signal=%0d cycle=%0d actual=%0d expected=%0d",
                             sbq[i].tag, sbq[i].id, cyc, got, sbq[i].val);
                end
                sbq.delete(i);
            end
        end
    end

    // Driver: present a write at a falling edge; it is captured on edge k.
    task automatic start_wr(input logic [1:0] a, input logic [15:0] d, output int kk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        kk = cyc + 1;
    endtask

    task automatic end_wr();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(20ns * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        tick(4);
        rst = 1'b0;
        // R1 reset state
        k = cyc + 1;
        expect_at(k, O_SEL, 0, "R1"); expect_at(k, O_PWR, 0, "R1");
        expect_at(k, O_MUL, 496, "R1"); expect_at(k, O_RDIV, 96, "R1");
        expect_at(k, O_RBYP, 0, "R1"); expect_at(k, O_ODIV, 0, "R1");
        expect_at(k, O_OEN, 0, "R1"); expect_at(k, O_BAD, 0, "R1");
        expect_at(k, O_SETL, 1, "R1"); expect_at(k, O_PEND, 0, "R1");
        tick(1);

        // R2 / R8: writes in bypass apply at once, restart the timer
        start_wr(2'd0, 16'd0, k);
        expect_at(k, O_MUL, 0, "R2"); expect_at(k, O_BAD, 1, "R8");
        end_wr();
        start_wr(2'd0, 16'd496, k1);
        expect_at(k1, O_MUL, 496, "R2"); expect_at(k1, O_BAD, 0, "R8");
        expect_at(k1, O_SETL, 1, "R2");
        end_wr();
        // R5 / R3: early request waits for expiry
        start_wr(2'd3, 16'h0001, k2);
        expect_at(k2, O_PEND, 1, "R5"); expect_at(k2, O_SEL, 0, "R5");
        expect_at(k1 + N, O_SEL, 0, "R3"); expect_at(k1 + N + 1, O_SEL, 1, "R3");
        expect_at(k1 + N + 1, O_PEND, 0, "R5"); expect_at(k1 + N + 1, O_ONPLL, 1, "R3");
        end_wr();
        tick(N + 2);

        // R4: ratio write while on the PLL
        start_wr(2'd2, 16'h0083, k);
        expect_at(k, O_SEL, 0, "R4"); expect_at(k, O_ODIV, 0, "R4");
        expect_at(k, O_OEN, 0, "R4");
        expect_at(k + 1, O_ODIV, 3, "R4"); expect_at(k + 1, O_OEN, 1, "R4");
        expect_at(k + N + 1, O_SEL, 0, "R4"); expect_at(k + N + 2, O_SEL, 1, "R4");
        end_wr();
        tick(N + 3);

        // R9: dropping the request returns to bypass and stays there
        start_wr(2'd3, 16'h0000, k);
        expect_at(k, O_SEL, 0, "R9"); expect_at(k, O_PEND, 0, "R9");
        expect_at(k + N + 3, O_SEL, 0, "R9");
        end_wr();
        tick(N + 4);

        // R3: timer long expired, grant on the capturing edge
        start_wr(2'd3, 16'h0001, k);
        expect_at(k, O_SEL, 1, "R3");
        end_wr();

        // R6: power-down from PLL operation
        start_wr(2'd3, 16'h0003, k);
        expect_at(k, O_SEL, 0, "R6"); expect_at(k, O_PWR, 0, "R6");
        expect_at(k + 1, O_PWR, 1, "R6");
        expect_at(k + N + 3, O_SEL, 0, "R6"); expect_at(k + N + 3, O_PWR, 1, "R6");
        expect_at(k + N + 3, O_PEND, 1, "R5");
        end_wr();
        tick(N + 4);

        // R2 / R8 while powered down: limits and boundaries
        start_wr(2'd1, 16'h1000, k);
        expect_at(k, O_RBYP, 1, "R2"); expect_at(k, O_BAD, 1, "R8");
        expect_at(k, O_PWR, 1, "R6");
        end_wr();
        start_wr(2'd1, 16'd96, k);
        expect_at(k, O_RBYP, 0, "R2"); expect_at(k, O_RDIV, 96, "R2");
        expect_at(k, O_BAD, 0, "R8");
        end_wr();
        start_wr(2'd0, 16'd495, k);
        expect_at(k, O_BAD, 1, "R8");
        end_wr();
        start_wr(2'd0, 16'd496, k);
        expect_at(k, O_BAD, 0, "R8");
        end_wr();
        start_wr(2'd1, 16'd1000, k);
        expect_at(k, O_BAD, 1, "R8");
        end_wr();
        start_wr(2'd1, 16'd96, k);
        expect_at(k, O_BAD, 0, "R8");
        end_wr();
        start_wr(2'd0, 16'd900, k);
        expect_at(k, O_BAD, 1, "R8");
        end_wr();
        start_wr(2'd0, 16'd496, k);
        expect_at(k, O_BAD, 0, "R8");
        end_wr();

        // R7: leave power-down, fresh settle interval
        start_wr(2'd3, 16'h0001, k);
        expect_at(k, O_PWR, 0, "R7"); expect_at(k, O_SETL, 1, "R7");
        expect_at(k + N, O_SEL, 0, "R7"); expect_at(k + N + 1, O_SEL, 1, "R7");
        end_wr();
        tick(N + 2);

        // R6: power-down from bypass is immediate
        start_wr(2'd3, 16'h0000, k);
        expect_at(k, O_SEL, 0, "R9");
        end_wr();
        tick(N + 3);
        start_wr(2'd3, 16'h0002, k);
        expect_at(k, O_PWR, 1, "R6"); expect_at(k, O_SEL, 0, "R6");
        end_wr();
        start_wr(2'd3, 16'h0000, k);
        expect_at(k, O_PWR, 0, "R7");
        end_wr();
        tick(N + 5);

        if (sbq.size() != 0) begin
            errors += sbq.size();
            checks += sbq.size();
            $display("FAIL scoreboard left %0d unchecked items actual=%0d expected=0",
                     sbq.size(), sbq.size());
        end
        finished = 1;
        summary();
        $finish;
    end

endmodule